// File: doc/BRIEF.md
# Stripmined Vector Sum Reduction Engine

The engine adds up a stream of N integers without a loop-carried adder chain. A start pulse loads the element count N. Elements then arrive over a valid/ready handshake and are spread across a vector of partial-sum slots, one slot per position within a chunk. The first chunk is the short one: it holds N modulo the slot count. Every chunk after it fills all slots. All arithmetic wraps modulo 2^DATA_W.

After the last element, the engine collapses the slot vector. On each step the active length halves, and the lower half of the slots adds in the matching upper half. When one slot is left, its value is the scalar result. The engine then raises done and holds the result until the next start. A count of zero finishes at once with a zero result. Each start clears every slot, so nothing carries over from one job to the next.

Top module: `vsum_reduce`

## Requirements
- R1: A start pulse accepted while idle or done, with N greater than 0, raises in_ready in the next cycle. An element is taken only in a cycle where in_valid and in_ready are both high.
- R2: sum_out equals the sum of all N accepted elements modulo 2^DATA_W once done is high.
- R3: Exactly N elements are accepted. The first chunk carries N mod SLOTS elements, or is skipped when that remainder is 0. Later chunks carry SLOTS elements each. in_ready stays high until the N-th handshake and is low in the cycle after it.
- R4: Every accepted start clears all partial-sum slots, so sum_out reads 0 in the cycle after the start, and earlier jobs never contaminate the result.
- R5: The fold takes log2(SLOTS) steps. done rises exactly log2(SLOTS)+1 cycles after the cycle in which the last element was presented and accepted, and in_ready stays low throughout the fold.
- R6: With N = 0, done is high and sum_out is 0 in the cycle after the start, and in_ready never rises.
- R7: While done is high and no start arrives, done and sum_out hold their values and in_ready stays low.
- R8: A start pulse raised while elements are being accepted or folded is ignored, and the running job still delivers its correct sum.
- R9: After reset, done and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job; honoured only when idle or done |
| n_elems | input | CNT_W | Element count N, sampled with start |
| in_valid | input | 1 | Element on in_data is valid |
| in_data | input | DATA_W | Element value |
| in_ready | output | 1 | Engine accepts an element this cycle |
| sum_out | output | DATA_W | Reduction result, valid while done is high |
| done | output | 1 | Result available |

## Verification
Two events can land in the same cycle. A start pulse can coincide with an element handshake while a job is accumulating. The last handshake of a chunk can also coincide with the switch from the remainder chunk to full chunks. The bench provokes the first case by raising start, with a zero count, in the same cycle that element 2 of a job is presented. The job must still finish with its own sum and must not end early with a zero result. It provokes the second case by sweeping N through every value from 0 to 200 and a few larger ones, with and without gaps in in_valid. Each run is judged on the arithmetic sum modulo 2^8, on the number of handshakes, and on the exact cycle in which done appears.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
   typedef enum logic [1:0] {
      VS_IDLE = 2'd0,
      VS_ACC  = 2'd1,
      VS_FOLD = 2'd2,
      VS_DONE = 2'd3
   } vsr_state_e;
endpackage

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
   import vsr_pkg::*;
#(
   parameter int SLOTS = 64,
   parameter int CNT_W = 16,
   localparam int LOGS = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] n_elems,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             clr,
   output logic             acc_en,
   output logic [LOGS-1:0]  acc_idx,
   output logic             fold_en,
   output logic [LOGS:0]    half,
   output vsr_state_e       st
);
   vsr_state_e       st_q;
   logic [CNT_W-1:0] remain_q;
   logic [LOGS-1:0]  idx_q;
   logic [LOGS-1:0]  last_q;
   logic [LOGS:0]    len_q;
   logic [LOGS-1:0]  rem_first;
   logic             can_start;

   // remainder chunk first; a zero remainder means the first chunk is full
   assign rem_first = n_elems[LOGS-1:0];
   assign can_start = start && (st_q == VS_IDLE || st_q == VS_DONE);
   assign in_ready  = (st_q == VS_ACC);
   assign acc_en    = in_ready && in_valid;
   assign acc_idx   = idx_q;
   assign fold_en   = (st_q == VS_FOLD);
   assign half      = len_q >> 1;
   assign clr       = can_start;
   assign st        = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= VS_IDLE;
         remain_q <= '0;
         idx_q    <= '0;
         last_q   <= '0;
         len_q    <= '0;
      end else if (can_start) begin
         idx_q    <= '0;
         remain_q <= n_elems;
         len_q    <= '0;
         if (rem_first == '0) last_q <= LOGS'(SLOTS - 1);
         else                 last_q <= rem_first - 1'b1;
         st_q <= (n_elems == '0) ? VS_DONE : VS_ACC;
      end else begin
         unique case (st_q)
            VS_ACC: if (acc_en) begin
               remain_q <= remain_q - 1'b1;
               if (remain_q == CNT_W'(1)) begin
                  st_q  <= VS_FOLD;
                  len_q <= (LOGS+1)'(SLOTS);
               end else if (idx_q == last_q) begin
                  idx_q  <= '0;
                  last_q <= LOGS'(SLOTS - 1);
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            VS_FOLD: begin
               len_q <= half;
               if (half == (LOGS+1)'(1)) st_q <= VS_DONE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/vsr_slots.sv
module vsr_slots #(
   parameter int SLOTS  = 64,
   parameter int DATA_W = 16,
   localparam int LOGS  = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              acc_en,
   input  logic [LOGS-1:0]   acc_idx,
   input  logic [DATA_W-1:0] in_data,
   input  logic              fold_en,
   input  logic [LOGS:0]     half,
   output logic [DATA_W-1:0] slot0
);
   logic [DATA_W-1:0] slot_q [SLOTS];

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      logic [DATA_W-1:0] nxt;
      logic [LOGS-1:0]   partner;
      assign partner = LOGS'(k) + half[LOGS-1:0];
      always_comb begin
         nxt = slot_q[k];
         if (fold_en && ((LOGS+1)'(k) < half))
            nxt = slot_q[k] + slot_q[partner];
         else if (acc_en && acc_idx == LOGS'(k))
            nxt = slot_q[k] + in_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   slot_q[k] <= '0;
         else if (clr) slot_q[k] <= '0;
         else          slot_q[k] <= nxt;
      end
   end

   assign slot0 = slot_q[0];
endmodule

// File: rtl/vsum_reduce.sv
module vsum_reduce
   import vsr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SLOTS  = 64,
   parameter int CNT_W  = 16,
   localparam int LOGS  = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  n_elems,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic [DATA_W-1:0] sum_out,
   output logic              done
);
   if (SLOTS < 2 || (1 << LOGS) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (CNT_W <= LOGS) begin : g_bad_cnt
      $error("CNT_W must exceed log2(SLOTS)");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic            clr, acc_en, fold_en;
   logic [LOGS-1:0] acc_idx;
   logic [LOGS:0]   half;
   vsr_state_e      st;

   vsr_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .n_elems(n_elems),
      .in_valid(in_valid), .in_ready(in_ready), .clr(clr),
      .acc_en(acc_en), .acc_idx(acc_idx), .fold_en(fold_en),
      .half(half), .st(st)
   );

   vsr_slots #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_slots (
      .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en),
      .acc_idx(acc_idx), .in_data(in_data), .fold_en(fold_en),
      .half(half), .slot0(sum_out)
   );

   assign done = (st == VS_DONE);
endmodule

// File: rtl/vsum_reduce_chk.sv
module vsum_reduce_chk
   import vsr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SLOTS  = 64,
   parameter int CNT_W  = 16,
   localparam int LOGS  = $clog2(SLOTS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  n_elems,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] sum_out,
   input logic              done,
   input vsr_state_e        st
);
   logic [LOGS+1:0] fcnt;
   logic            idle_like;
   assign idle_like = (st == VS_IDLE) || (st == VS_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              fcnt <= '0;
      else if (st == VS_FOLD)  fcnt <= fcnt + 1'b1;
      else                     fcnt <= '0;
   end

   AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
      idle_like && start && n_elems != '0 |=> in_ready); // R1
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      idle_like && start |=> sum_out == '0); // R4
   AST_FOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      st == VS_FOLD |-> fcnt < (LOGS+2)'(LOGS)); // R5
   AST_FOLD_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      st == VS_DONE && $past(st) == VS_FOLD |-> fcnt == (LOGS+2)'(LOGS)); // R5
   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      idle_like && start && n_elems == '0 |=> done && sum_out == '0); // R6
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done && $stable(sum_out)); // R7
   AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready); // R7
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      st == VS_ACC && start && !in_valid |=> st == VS_ACC); // R8
endmodule

bind vsum_reduce vsum_reduce_chk #(.DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .n_elems(n_elems),
   .in_valid(in_valid), .in_ready(in_ready), .sum_out(sum_out),
   .done(done), .st(st)
);

// File: tb/sim_vsum_reduce.sv
module sim_vsum_reduce;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int SL = 64;
   localparam int LG = 6;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] n_elems = '0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready;
   logic [DW-1:0] sum_out;
   logic          done;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] lfsr = 16'hACE1;

   vsum_reduce #(.DATA_W(DW), .SLOTS(SL), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .n_elems(n_elems),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .sum_out(sum_out), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 190000);
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] elem(input int n, input int k);
      return DW'(n * 7 + k * 13 + 5);
   endfunction

   task automatic run_case(input int n, input bit gaps, input bit poke);
      logic [DW-1:0] expv;
      int k;
      int steps;
      logic [DW-1:0] held;
      bit v;
      @(negedge clk);
      start = 1'b1;
      n_elems = CW'(n);
      in_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      expv = '0;
      k = 0;
      if (n == 0) begin
         chk(done == 1'b1, "R6", int'(done), 1);
         chk(sum_out == '0, "R6", int'(sum_out), 0);
         chk(in_ready == 1'b0, "R6", int'(in_ready), 0);
      end else begin
         chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
         chk(sum_out == '0, "R4", int'(sum_out), 0);
         while (k < n) begin
            v = gaps ? lfsr[0] : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (poke && k == 2 && v) begin
               start = 1'b1;
               n_elems = '0;
            end else begin
               start = 1'b0;
            end
            in_valid = v;
            in_data = elem(n, k);
            if (!in_ready) chk(1'b0, "R3", int'(in_ready), 1);
            if (v) begin
               expv = expv + in_data;
               k++;
            end
            @(negedge clk);
         end
         start = 1'b0;
         in_valid = 1'b0;
         chk(in_ready == 1'b0, "R3", int'(in_ready), 0);
         steps = 1;
         while (!done && steps < 40) begin
            if (in_ready) chk(1'b0, "R5", int'(in_ready), 0);
            @(negedge clk);
            steps++;
         end
         chk(steps == LG + 1, "R5", steps, LG + 1);
         chk(sum_out == expv, poke ? "R8" : "R2", int'(sum_out), int'(expv));
      end
      held = sum_out;
      repeat (3) @(negedge clk);
      chk(done == 1'b1, "R7", int'(done), 1);
      chk(sum_out == held, "R7", int'(sum_out), int'(held));
      chk(in_ready == 1'b0, "R7", int'(in_ready), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R9", int'(done), 0);
      chk(in_ready == 1'b0, "R9", int'(in_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R9", int'(done), 0);
      for (int n = 0; n <= 200; n++) run_case(n, 1'b0, 1'b0);
      run_case(1, 1'b1, 1'b0);
      run_case(5, 1'b1, 1'b0);
      run_case(63, 1'b1, 1'b0);
      run_case(64, 1'b1, 1'b0);
      run_case(65, 1'b1, 1'b0);
      run_case(128, 1'b1, 1'b0);
      run_case(129, 1'b1, 1'b0);
      run_case(300, 1'b1, 1'b0);
      run_case(0, 1'b1, 1'b0);
      run_case(10, 1'b0, 1'b1);
      run_case(70, 1'b1, 1'b1);
      run_case(0, 1'b0, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule